// File: doc/BRIEF.md
# LAPD Receive Address Filter

This block sits behind an HDLC deframer on the receive side of a D-channel link. It takes octets one per cycle, together with a start-of-frame marker that comes with the first octet and an end-of-frame strobe. From the two address octets at the head of each frame it decides whether the frame belongs to this terminal. The first octet holds the service access point identifier and the second holds the terminal endpoint identifier. It emits one decision pulse per frame. The pulse carries an accept flag and a code naming which address combination matched.

The block holds six 8-bit configuration registers, loaded through a simple write strobe: two individual SAPI octets, two individual TEI octets, and one compare-mask octet for each position. The individual comparisons honour the masks. The broadcast values are fixed, and the masks never reach them: the SAPI octets 0xFE and 0xFC (SAPI 63, layer management) and the TEI octet 0xFF (TEI 127, automatic assignment). Only seven of the possible pairings are accepted. A bypass input lets every complete frame through.

Top module: `lapd_addr_filter`

## Requirements
- R1: After reset `dec_valid` and `accept` are 0 and `match_id` is 7. All six configuration registers reset to 0x00.
- R2: A write with `cfg_we`=1 loads `cfg_wdata` into the register that `cfg_sel` selects: 0 individual SAPI A, 1 individual SAPI B, 2 individual TEI A, 3 individual TEI B, 4 SAPI mask, 5 TEI mask. Codes 6 and 7 change nothing.
- R3: Individual pairs are accepted with these codes: SAPI A with TEI A gives 0, SAPI A with TEI 0xFF gives 1, SAPI B with TEI B gives 2, and SAPI B with TEI 0xFF gives 3.
- R4: A SAPI octet of 0xFE or 0xFC is accepted with these codes: with TEI A it gives 4, with TEI B it gives 5, and with TEI 0xFF it gives 6.
- R5: Every other combination, including the cross pairs SAPI A with TEI B and SAPI B with TEI A, is rejected with `accept`=0 and `match_id`=7.
- R6: A mask bit set to 1 excludes that bit position from the comparison of the received octet with both individual values at that position.
- R7: The masks never alter the comparison with 0xFE, 0xFC or 0xFF.
- R8: When several pairs match, the lowest code is reported.
- R9: The octet that arrives with `frame_start` is the SAPI octet, and the next valid octet is the TEI octet. `dec_valid` pulses for exactly one cycle, in the cycle after the TEI octet. Later octets of the same frame produce no further pulse. A new `frame_start` restarts the address capture.
- R10: When `filt_en` is 0, every frame with two address octets is accepted. `match_id` still reports the pair found, or 7 if none matched.
- R11: If `frame_end` arrives while only the SAPI octet has been received, `dec_valid` pulses in the next cycle with `accept`=0 and `match_id`=7, whatever the value of `filt_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| filt_en | input | 1 | 1 = filter active, 0 = accept all complete frames |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select for a write |
| cfg_wdata | input | 8 | Configuration write data |
| byte_valid | input | 1 | `byte_data` carries a received octet |
| byte_data | input | 8 | Received octet |
| frame_start | input | 1 | Marks the first octet of a frame, qualified by `byte_valid` |
| frame_end | input | 1 | The current frame has ended |
| dec_valid | output | 1 | One-cycle decision strobe |
| accept | output | 1 | The frame is for this terminal, valid with `dec_valid` |
| match_id | output | 3 | Matched pair code 0..6, or 7 for none |

## Verification
Most internal faults show up in the decision strobe that belongs to the frame under test, one cycle after its TEI octet. A stale captured SAPI octet, a mask bit leaking into a broadcast comparison, or a swapped pair code all give a wrong `accept` or `match_id` on that strobe. A corrupted capture state shows up differently. Either a strobe is missing for a short frame, or an extra strobe appears on a payload octet, no later than the cycle after the stray octet or end strobe. Configuration faults stay hidden until a frame uses the affected register, so each register is exercised by at least one frame directed at it.

// File: rtl/lapd_filt_pkg.sv
package lapd_filt_pkg;

    localparam int OCT_W = 8;
    localparam int ID_W  = 3;

    typedef enum logic [ID_W-1:0] {
        PAIR_SA_TA  = 3'd0,
        PAIR_SA_TG  = 3'd1,
        PAIR_SB_TB  = 3'd2,
        PAIR_SB_TG  = 3'd3,
        PAIR_SG_TA  = 3'd4,
        PAIR_SG_TB  = 3'd5,
        PAIR_SG_TG  = 3'd6,
        PAIR_NONE   = 3'd7
    } pair_id_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WANT_TEI = 2'd1,
        ST_DONE     = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic [OCT_W-1:0] sapi_a;
        logic [OCT_W-1:0] sapi_b;
        logic [OCT_W-1:0] tei_a;
        logic [OCT_W-1:0] tei_b;
        logic [OCT_W-1:0] sapi_msk;
        logic [OCT_W-1:0] tei_msk;
    } addr_cfg_t;

    typedef struct packed {
        cap_state_e       st;
        logic [OCT_W-1:0] sapi_oct;
        logic             dec_valid;
        logic             accept;
        pair_id_e         match_id;
    } cap_regs_t;

endpackage

// File: rtl/lapd_filt_cfg.sv
module lapd_filt_cfg
    import lapd_filt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [OCT_W-1:0] cfg_wdata,
    output addr_cfg_t        cfg
);

    addr_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_sel)
                3'd0:    cfg_d.sapi_a   = cfg_wdata;
                3'd1:    cfg_d.sapi_b   = cfg_wdata;
                3'd2:    cfg_d.tei_a    = cfg_wdata;
                3'd3:    cfg_d.tei_b    = cfg_wdata;
                3'd4:    cfg_d.sapi_msk = cfg_wdata;
                3'd5:    cfg_d.tei_msk  = cfg_wdata;
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/lapd_octet_match.sv
module lapd_octet_match #(
    parameter int                           W      = 8,
    parameter int                           N_IND  = 2,
    parameter int                           N_GRP  = 1,
    parameter logic [N_GRP-1:0][W-1:0]      GRP_VALS = '1
) (
    input  logic [W-1:0]              oct,
    input  logic [N_IND-1:0][W-1:0]   ind_vals,
    input  logic [W-1:0]              msk,
    output logic [N_IND-1:0]          ind_hit,
    output logic                      grp_hit
);

    logic [N_GRP-1:0] grp_each;

    for (genvar i = 0; i < N_IND; i++) begin : g_ind
        assign ind_hit[i] = (((oct ^ ind_vals[i]) & ~msk) == '0);
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign grp_each[g] = (oct == GRP_VALS[g]);
    end

    assign grp_hit = |grp_each;

endmodule

// File: rtl/lapd_pair_pick.sv
module lapd_pair_pick
    import lapd_filt_pkg::*;
(
    input  logic [1:0] s_ind,
    input  logic       s_grp,
    input  logic [1:0] t_ind,
    input  logic       t_grp,
    output pair_id_e   pick
);

    localparam int N_PAIR = 7;

    logic [N_PAIR-1:0] pair_hit;

    always_comb begin
        pair_hit[0] = s_ind[0] & t_ind[0];
        pair_hit[1] = s_ind[0] & t_grp;
        pair_hit[2] = s_ind[1] & t_ind[1];
        pair_hit[3] = s_ind[1] & t_grp;
        pair_hit[4] = s_grp    & t_ind[0];
        pair_hit[5] = s_grp    & t_ind[1];
        pair_hit[6] = s_grp    & t_grp;
    end

    always_comb begin
        pick = PAIR_NONE;
        for (int k = N_PAIR - 1; k >= 0; k--) begin
            if (pair_hit[k]) pick = pair_id_e'(k[ID_W-1:0]);
        end
    end

endmodule

// File: rtl/lapd_addr_filter.sv
module lapd_addr_filter
    import lapd_filt_pkg::*;
#(
    parameter logic [7:0] GRP_SAPI_P = 8'hFE,
    parameter logic [7:0] GRP_SAPI_S = 8'hFC,
    parameter logic [7:0] GRP_TEI    = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       filt_en,
    input  logic       cfg_we,
    input  logic [2:0] cfg_sel,
    input  logic [7:0] cfg_wdata,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       frame_start,
    input  logic       frame_end,
    output logic       dec_valid,
    output logic       accept,
    output logic [2:0] match_id
);

    addr_cfg_t cfg;
    cap_regs_t r_d, r_q;
    logic [1:0] s_ind, t_ind;
    logic       s_grp, t_grp;
    pair_id_e   pick;

    lapd_filt_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    // SAPI position: compared from the captured first octet
    lapd_octet_match #(
        .W        (OCT_W),
        .N_IND    (2),
        .N_GRP    (2),
        .GRP_VALS ({GRP_SAPI_S, GRP_SAPI_P})
    ) u_sapi_cmp (
        .oct      (r_q.sapi_oct),
        .ind_vals ({cfg.sapi_b, cfg.sapi_a}),
        .msk      (cfg.sapi_msk),
        .ind_hit  (s_ind),
        .grp_hit  (s_grp)
    );

    // TEI position: compared from the octet on the input
    lapd_octet_match #(
        .W        (OCT_W),
        .N_IND    (2),
        .N_GRP    (1),
        .GRP_VALS (GRP_TEI)
    ) u_tei_cmp (
        .oct      (byte_data),
        .ind_vals ({cfg.tei_b, cfg.tei_a}),
        .msk      (cfg.tei_msk),
        .ind_hit  (t_ind),
        .grp_hit  (t_grp)
    );

    lapd_pair_pick u_pick (
        .s_ind (s_ind),
        .s_grp (s_grp),
        .t_ind (t_ind),
        .t_grp (t_grp),
        .pick  (pick)
    );

    always_comb begin
        r_d           = r_q;
        r_d.dec_valid = 1'b0;
        r_d.accept    = 1'b0;
        r_d.match_id  = PAIR_NONE;
        if (byte_valid && frame_start) begin
            r_d.st       = ST_WANT_TEI;
            r_d.sapi_oct = byte_data;
        end else begin
            case (r_q.st)
                ST_WANT_TEI: begin
                    if (byte_valid) begin
                        r_d.dec_valid = 1'b1;
                        r_d.match_id  = pick;
                        r_d.accept    = !filt_en || (pick != PAIR_NONE);
                        r_d.st        = frame_end ? ST_IDLE : ST_DONE;
                    end else if (frame_end) begin
                        r_d.dec_valid = 1'b1;
                        r_d.st        = ST_IDLE;
                    end
                end
                ST_DONE: begin
                    if (frame_end) r_d.st = ST_IDLE;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= ST_IDLE;
            r_q.sapi_oct  <= '0;
            r_q.dec_valid <= 1'b0;
            r_q.accept    <= 1'b0;
            r_q.match_id  <= PAIR_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign dec_valid = r_q.dec_valid;
    assign accept    = r_q.accept;
    assign match_id  = r_q.match_id;

endmodule

// File: rtl/lapd_addr_filter_chk.sv
module lapd_addr_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid,
    input logic       frame_end,
    input logic       dec_valid,
    input logic       accept,
    input logic [2:0] match_id
);

    // R1
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!accept && match_id == 3'd7));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R9
    pulse_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(byte_valid || frame_end));

    // R11
    short_frame_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !$past(byte_valid)) |-> (!accept && match_id == 3'd7));

    // R3
    match_means_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && match_id != 3'd7) |-> accept);

endmodule

bind lapd_addr_filter lapd_addr_filter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .frame_end  (frame_end),
    .dec_valid  (dec_valid),
    .accept     (accept),
    .match_id   (match_id)
);

// File: tb/lapd_addr_filter_test.sv
module lapd_addr_filter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       filt_en = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       frame_start = 1'b0;
    logic       frame_end = 1'b0;
    logic       dec_valid, accept;
    logic [2:0] match_id;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lapd_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .filt_en(filt_en),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .frame_start(frame_start), .frame_end(frame_end),
        .dec_valid(dec_valid), .accept(accept), .match_id(match_id)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Two address octets, then one payload octet; decision expected one
    // cycle after the TEI octet, and no second strobe afterwards.
    task automatic frame(string req, logic [7:0] s, logic [7:0] t,
                         logic exp_acc, logic [2:0] exp_id);
        @(negedge clk);
        byte_valid = 1'b1; frame_start = 1'b1; byte_data = s;
        @(negedge clk);
        frame_start = 1'b0; byte_data = t;
        @(negedge clk);
        byte_data = 8'h5A;
        check({req, " strobe"}, dec_valid, 1'b1);
        check({req, " accept"}, accept, exp_acc);
        check({req, " id"}, match_id, exp_id);
        @(negedge clk);
        byte_valid = 1'b0;
        check({req, " R9 payload ignored"}, dec_valid, 1'b0);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        check({req, " R9 end after decision"}, dec_valid, 1'b0);
    endtask

    task automatic test_reset();
        check("R1 dec_valid", dec_valid, 1'b0);
        check("R1 accept", accept, 1'b0);
        check("R1 match_id", match_id, 3'd7);
        // R1: registers reset to 0x00, so SAPI 00 + TEI 00 is pair 0
        frame("R1 cfg zero", 8'h00, 8'h00, 1'b1, 3'd0);
    endtask

    task automatic test_cfg();
        wr(3'd0, 8'h08); wr(3'd1, 8'h0C); wr(3'd2, 8'h85); wr(3'd3, 8'h03);
        wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        // R2: unused selects leave all registers alone
        wr(3'd6, 8'h44); wr(3'd7, 8'h44);
        frame("R2 sel 6/7", 8'h08, 8'h85, 1'b1, 3'd0);
    endtask

    task automatic test_individual();
        frame("R3 A+A", 8'h08, 8'h85, 1'b1, 3'd0);
        frame("R3 A+grp", 8'h08, 8'hFF, 1'b1, 3'd1);
        frame("R3 B+B", 8'h0C, 8'h03, 1'b1, 3'd2);
        frame("R3 B+grp", 8'h0C, 8'hFF, 1'b1, 3'd3);
    endtask

    task automatic test_group();
        frame("R4 FE+A", 8'hFE, 8'h85, 1'b1, 3'd4);
        frame("R4 FC+B", 8'hFC, 8'h03, 1'b1, 3'd5);
        frame("R4 FE+grp", 8'hFE, 8'hFF, 1'b1, 3'd6);
        frame("R4 FC+grp", 8'hFC, 8'hFF, 1'b1, 3'd6);
    endtask

    task automatic test_reject();
        frame("R5 A+B cross", 8'h08, 8'h03, 1'b0, 3'd7);
        frame("R5 B+A cross", 8'h0C, 8'h85, 1'b0, 3'd7);
        frame("R5 unknown", 8'h10, 8'h85, 1'b0, 3'd7);
        frame("R5 FD not grp", 8'hFD, 8'hFF, 1'b0, 3'd7);
    endtask

    task automatic test_mask();
        wr(3'd4, 8'h02);
        frame("R6 sapi mask", 8'h0A, 8'h85, 1'b1, 3'd0);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'hF0);
        frame("R6 tei mask", 8'h0C, 8'hF3, 1'b1, 3'd2);
        wr(3'd5, 8'h00);
        frame("R6 unmasked bit", 8'h0A, 8'h85, 1'b0, 3'd7);
        // R7: masking bit 0 must not make FF look like FE, or FE like FF
        wr(3'd4, 8'h01);
        frame("R7 sapi grp exact", 8'hFF, 8'hFF, 1'b0, 3'd7);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h01);
        frame("R7 tei grp exact", 8'hFE, 8'hFE, 1'b0, 3'd7);
        wr(3'd5, 8'h00);
    endtask

    task automatic test_priority();
        wr(3'd2, 8'hFF);
        frame("R8 lowest code", 8'h08, 8'hFF, 1'b1, 3'd0);
        frame("R8 grp lowest", 8'hFE, 8'hFF, 1'b1, 3'd4);
        wr(3'd2, 8'h85);
    endtask

    task automatic test_restart();
        @(negedge clk);
        byte_valid = 1'b1; frame_start = 1'b1; byte_data = 8'h10;
        @(negedge clk);
        byte_data = 8'h0C;
        @(negedge clk);
        frame_start = 1'b0; byte_data = 8'h03;
        check("R9 no strobe on restart", dec_valid, 1'b0);
        @(negedge clk);
        byte_valid = 1'b0;
        check("R9 restart strobe", dec_valid, 1'b1);
        check("R9 restart id", match_id, 3'd2);
    endtask

    task automatic test_bypass();
        filt_en = 1'b0;
        frame("R10 bypass unknown", 8'h10, 8'h20, 1'b1, 3'd7);
        frame("R10 bypass match id", 8'h0C, 8'hFF, 1'b1, 3'd3);
        filt_en = 1'b1;
    endtask

    task automatic short_frame(string req);
        @(negedge clk);
        byte_valid = 1'b1; frame_start = 1'b1; byte_data = 8'h08;
        @(negedge clk);
        byte_valid = 1'b0; frame_start = 1'b0; frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        check({req, " strobe"}, dec_valid, 1'b1);
        check({req, " accept"}, accept, 1'b0);
        check({req, " id"}, match_id, 3'd7);
        @(negedge clk);
        check({req, " single"}, dec_valid, 1'b0);
    endtask

    task automatic test_short();
        short_frame("R11 short");
        filt_en = 1'b0;
        short_frame("R11 short bypass");
        filt_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_cfg();
        test_individual();
        test_group();
        test_reject();
        test_mask();
        test_priority();
        test_restart();
        test_bypass();
        test_short();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule